// File: doc/BRIEF.md
# Multi-Mode Reloadable Timer

This block is a 16-bit up-counting timer for a larger chip. It counts from a software-written start value up to a 16-bit limit register. When the count equals the limit at a counting step, the count restarts at 0001h. Steps come either from a power-of-two clock divider or from active edges on an external input. A mode code selects one of five behaviours: single pass, free running, external-edge counting, single-output pulse-width modulation, and input capture. Each byte of the count, the limit, the match/capture register, the control byte and the mode byte can be read and written individually.

A polarity bit has two roles. It sets the idle level of the timer output. It also picks which input edge is active. The block has one timer output pin. It raises a one-cycle interrupt pulse at each limit restart and at each capture.

The sequencing is a two-state machine. IDLE is the stopped state: the divider is held at zero and the count does not move. RUN is the counting state. The transitions are:
- START (IDLE to RUN): a control write with the enable bit set.
- STOP (RUN to IDLE): a control write with the enable bit clear.
- EXPIRE (RUN to IDLE): a limit restart in single-pass mode.

A control write with the enable bit set while in RUN keeps RUN.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads 00h, the timer is in IDLE, and both `tmr_out` and `irq` are low.
- R2: Register map, by byte address:
  - 0 and 1: count, high byte and low byte.
  - 2 and 3: limit, high byte and low byte.
  - 4 and 5: match/capture register, high byte and low byte.
  - 6: control byte. Bit 7 is enable and reads back as 1 in RUN. Bit 6 is polarity. Bits 5:3 are the divider exponent P.
  - 7: mode code in bits 3:0.
  - Written limit, match and mode values read back unchanged.
- R3: Mode codes are 0000 single pass, 0001 free running, 0010 edge counting, 0011 pulse-width output, 0100 capture. In every mode except edge counting, the count advances once every 2^P clocks. The first advance is 2^P clocks after the START edge.
- R4: Leaving RUN clears the divider. After a STOP and a new START, the first advance again comes 2^P clocks after the START edge, whatever the divider held before the STOP.
- R5: At a step where count equals limit, several things happen on that same edge:
  - The count becomes 0001h.
  - `irq` is high for exactly one cycle.
  - In single-pass, free-running and edge-counting modes, `tmr_out` toggles.
- R6: In single-pass mode the limit restart also takes the EXPIRE transition. After it the enable bit reads 0 and the count stays at 0001h.
- R7: A byte write to the count loads that byte at the write edge, even while running. The other byte keeps its current value, and counting continues from the new value.
- R8: In edge-counting mode the count advances on synchronized active edges of `tmr_in`. The active edge is rising when polarity is 0 and falling when it is 1. The divider is not used. The change shows after the third rising clock edge following the input change. Inactive edges leave the count unchanged.
- R9: In pulse-width mode, `tmr_out` goes to the inverse of polarity at the step where the count equals the match register. It returns to the polarity level at the limit restart.
- R10: In capture mode an active input edge copies the count into the match/capture register and pulses `irq`. The counter keeps running.
- R11: A control write with the enable bit clear, or any control write while in IDLE, sets `tmr_out` to the new polarity bit.
- R12: While RUN holds an undefined mode code (0101 to 1111), the count and `tmr_out` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 3 | Byte read address |
| rd_data | output | 8 | Byte read data, combinational from rd_addr |
| tmr_in | input | 1 | Timer input, asynchronous |
| tmr_out | output | 1 | Timer output |
| irq | output | 1 | Interrupt pulse on limit restart or capture |

## Verification
Every register write takes effect at the rising edge that samples the strobe, so readback and output checks are taken one nanosecond after that edge. A divider-driven step lands exactly 2^P edges after the START edge, and the bench samples one edge before and one edge on each such boundary. An input change takes effect on the third edge after it: two synchronizer stages plus the edge detector. The bench therefore checks the count as unchanged after two edges and as advanced after the third. Limit restarts, pulse-width transitions and capture are all registered on the step edge, so `irq`, `tmr_out` and the captured value are sampled right after that edge, and again one edge later to confirm the single-cycle pulse.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;
    typedef enum logic [3:0] {
        MODE_ONESHOT = 4'b0000,
        MODE_CONT    = 4'b0001,
        MODE_COUNTER = 4'b0010,
        MODE_PWM     = 4'b0011,
        MODE_CAPTURE = 4'b0100
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    localparam int REG_ADDR_W = 3;
    localparam logic [REG_ADDR_W-1:0] A_CNT_HI = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_RLD_HI = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_RLD_LO = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_CMP_HI = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_CMP_LO = 3'd5;
    localparam logic [REG_ADDR_W-1:0] A_CTRL   = 3'd6;
    localparam logic [REG_ADDR_W-1:0] A_MODE   = 3'd7;
endpackage

// File: rtl/rtmr_prescaler.sv
`timescale 1ns/1ps
module rtmr_prescaler #(
    parameter int PRES_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRES_W-1:0] pres,
    output logic              tick
);
    localparam int DIV_W = (1 << PRES_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = ~({DIV_W{1'b1}} << pres);
    assign tick = run && ((div_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + DIV_W'(1);
        end else begin
            div_q <= '0;
        end
    end

    // R4: each start of counting begins from a cleared divider
    a_r4_fresh_divider: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (div_q == '0));
endmodule

// File: rtl/rtmr_in_edge.sv
`timescale 1ns/1ps
module rtmr_in_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic act
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   now_lvl;
    logic                   was_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign now_lvl = sync_q[SYNC_STAGES-1] ^ pol;
    assign was_lvl = prev_q ^ pol;
    assign act     = now_lvl && !was_lvl;

    // R8: an active edge is reported for one cycle only
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> (!act || (pol != $past(pol))));
endmodule

// File: rtl/reload_timer.sv
`timescale 1ns/1ps
module reload_timer
    import rtmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PRES_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0]     rd_data,
    input  logic                  tmr_in,
    output logic                  tmr_out,
    output logic                  irq
);
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int EN_BIT   = BYTE_W - 1;
    localparam int POL_BIT  = BYTE_W - 2;
    localparam int PRES_LSB = BYTE_W - 2 - PRES_W;
    localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

    state_e state_q, state_d;

    logic [CNT_W-1:0]  cnt_q, rld_q, cmp_q;
    logic [PRES_W-1:0] pres_q;
    logic [3:0]        mode_q;
    logic              pol_q, out_q, irq_q;

    logic wr_cnt_hi, wr_cnt_lo, wr_rld_hi, wr_rld_lo;
    logic wr_cmp_hi, wr_cmp_lo, wr_ctrl, wr_mode, wr_cnt_any;
    logic running, mode_ok, tick, in_act;
    logic step, reload_hit, match_hit, cap_hit;

    assign wr_cnt_hi  = wr_en && (wr_addr == A_CNT_HI);
    assign wr_cnt_lo  = wr_en && (wr_addr == A_CNT_LO);
    assign wr_rld_hi  = wr_en && (wr_addr == A_RLD_HI);
    assign wr_rld_lo  = wr_en && (wr_addr == A_RLD_LO);
    assign wr_cmp_hi  = wr_en && (wr_addr == A_CMP_HI);
    assign wr_cmp_lo  = wr_en && (wr_addr == A_CMP_LO);
    assign wr_ctrl    = wr_en && (wr_addr == A_CTRL);
    assign wr_mode    = wr_en && (wr_addr == A_MODE);
    assign wr_cnt_any = wr_cnt_hi || wr_cnt_lo;

    assign running = (state_q == ST_RUN);
    assign mode_ok = (mode_q <= 4'(MODE_CAPTURE));

    rtmr_prescaler #(.PRES_W(PRES_W)) u_prescaler (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .pres (pres_q),
        .tick (tick)
    );

    rtmr_in_edge #(.SYNC_STAGES(SYNC_STAGES)) u_in_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (tmr_in),
        .pol  (pol_q),
        .act  (in_act)
    );

    assign step       = running && mode_ok &&
                        ((mode_q == 4'(MODE_COUNTER)) ? in_act : tick);
    assign reload_hit = step && (cnt_q == rld_q);
    assign match_hit  = step && !reload_hit &&
                        (mode_q == 4'(MODE_PWM)) && (cnt_q == cmp_q);
    assign cap_hit    = running && (mode_q == 4'(MODE_CAPTURE)) && in_act;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, STOP, EXPIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ctrl && wr_data[EN_BIT]) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (wr_ctrl) begin
                    state_d = wr_data[EN_BIT] ? ST_RUN : ST_IDLE;
                end else if (reload_hit && (mode_q == 4'(MODE_ONESHOT))) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rld_q  <= '0;
            cmp_q  <= '0;
            pres_q <= '0;
            mode_q <= '0;
            pol_q  <= 1'b0;
            out_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= reload_hit || cap_hit;

            if (wr_cnt_any) begin
                if (wr_cnt_hi) cnt_q[CNT_W-1 -: BYTE_W] <= wr_data;
                if (wr_cnt_lo) cnt_q[BYTE_W-1:0]        <= wr_data;
            end else if (reload_hit) begin
                cnt_q <= RESTART;
            end else if (step) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end

            if (wr_rld_hi) rld_q[CNT_W-1 -: BYTE_W] <= wr_data;
            if (wr_rld_lo) rld_q[BYTE_W-1:0]        <= wr_data;

            if (cap_hit) begin
                cmp_q <= cnt_q;
            end else begin
                if (wr_cmp_hi) cmp_q[CNT_W-1 -: BYTE_W] <= wr_data;
                if (wr_cmp_lo) cmp_q[BYTE_W-1:0]        <= wr_data;
            end

            if (wr_ctrl) begin
                pol_q  <= wr_data[POL_BIT];
                pres_q <= wr_data[PRES_LSB +: PRES_W];
            end
            if (wr_mode) mode_q <= wr_data[3:0];

            if (wr_ctrl && (!wr_data[EN_BIT] || !running)) begin
                out_q <= wr_data[POL_BIT];
            end else if (reload_hit) begin
                if (mode_q == 4'(MODE_PWM)) begin
                    out_q <= pol_q;
                end else if (mode_q != 4'(MODE_CAPTURE)) begin
                    out_q <= ~out_q;
                end
            end else if (match_hit) begin
                out_q <= ~pol_q;
            end
        end
    end

    assign tmr_out = out_q;
    assign irq     = irq_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CNT_HI: rd_data = cnt_q[CNT_W-1 -: BYTE_W];
            A_CNT_LO: rd_data = cnt_q[BYTE_W-1:0];
            A_RLD_HI: rd_data = rld_q[CNT_W-1 -: BYTE_W];
            A_RLD_LO: rd_data = rld_q[BYTE_W-1:0];
            A_CMP_HI: rd_data = cmp_q[CNT_W-1 -: BYTE_W];
            A_CMP_LO: rd_data = cmp_q[BYTE_W-1:0];
            A_CTRL: begin
                rd_data[EN_BIT]                 = running;
                rd_data[POL_BIT]                = pol_q;
                rd_data[PRES_LSB +: PRES_W]     = pres_q;
            end
            A_MODE:   rd_data[3:0] = mode_q;
        endcase
    end

    // R5: a limit match restarts the count at 0001h
    a_r5_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_hit && !wr_cnt_any) |=> (cnt_q == RESTART));

    // R6: single pass stops and flips the output
    a_r6_oneshot_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_hit && (mode_q == 4'(MODE_ONESHOT)) && !wr_ctrl) |=>
        ((state_q == ST_IDLE) && (tmr_out != $past(tmr_out))));

    // R9: pulse-width output returns to the idle level at restart
    a_r9_pwm_back: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_hit && (mode_q == 4'(MODE_PWM)) && !wr_ctrl) |=>
        (tmr_out == $past(pol_q)));

    // R10: capture takes the count present at the edge
    a_r10_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (cmp_q == $past(cnt_q)));

    // R12: undefined mode codes freeze the count
    a_r12_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !mode_ok && !wr_cnt_any) |=> $stable(cnt_q));
endmodule

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
    import rtmr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tmr_in = 1'b0;
    logic       tmr_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    reload_timer u_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_in(tmr_in), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; tmr_in = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] hi, input logic [15:0] v);
        wr(hi, v[15:8]);
        wr(hi + 3'd1, v[7:0]);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a; #0.2;
        d = rd_data;
    endtask

    task automatic rd16(input logic [2:0] hi, output logic [15:0] v);
        logic [7:0] h, l;
        rd(hi, h);
        rd(hi + 3'd1, l);
        v = {h, l};
    endtask

    task automatic pulse_in;
        @(negedge clk); tmr_in = 1'b1;
        repeat (4) @(negedge clk); tmr_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_map;
        logic [7:0] d;
        logic [15:0] v;
        do_reset();
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 register after reset", d, 0);
        end
        check("R1 tmr_out after reset", tmr_out, 0);
        check("R1 irq after reset", irq, 0);
        wr16(A_RLD_HI, 16'hABCD);
        wr16(A_CMP_HI, 16'h5A3C);
        wr(A_MODE, 8'h03);
        rd16(A_RLD_HI, v); check("R2 limit readback", v, 16'hABCD);
        rd16(A_CMP_HI, v); check("R2 match readback", v, 16'h5A3C);
        rd(A_MODE, d);     check("R2 mode readback", d, 8'h03);
    endtask

    task automatic t_continuous;
        logic [15:0] v;
        do_reset();
        wr16(A_RLD_HI, 16'h0004);
        wr(A_MODE, 8'h01);
        wr(A_CTRL, 8'h80);
        cyc(4);
        rd16(A_CNT_HI, v); check("R3 count at limit", v, 4);
        check("R5 irq before restart", irq, 0);
        cyc(1);
        rd16(A_CNT_HI, v); check("R5 restart to 0001h", v, 1);
        check("R5 irq at restart", irq, 1);
        check("R5 output toggled", tmr_out, 1);
        cyc(1);
        check("R5 irq single cycle", irq, 0);
        cyc(3);
        check("R5 output toggled back", tmr_out, 0);
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        do_reset();
        wr16(A_RLD_HI, 16'hFFFF);
        wr(A_MODE, 8'h01);
        wr(A_CTRL, 8'h90);
        cyc(3);
        rd16(A_CNT_HI, v); check("R3 no step before 4 clocks", v, 0);
        cyc(1);
        rd16(A_CNT_HI, v); check("R3 first step at 4 clocks", v, 1);
        cyc(4);
        rd16(A_CNT_HI, v); check("R3 second step at 8 clocks", v, 2);
        cyc(1);
        rd16(A_CNT_HI, v); check("R3 no extra step", v, 2);
    endtask

    task automatic t_divider_clear;
        logic [15:0] v;
        do_reset();
        wr16(A_RLD_HI, 16'hFFFF);
        wr(A_MODE, 8'h01);
        wr(A_CTRL, 8'h98);
        cyc(4);
        wr(A_CTRL, 8'h18);
        wr(A_CTRL, 8'h98);
        cyc(7);
        rd16(A_CNT_HI, v); check("R4 divider restarted, no early step", v, 0);
        cyc(1);
        rd16(A_CNT_HI, v); check("R4 step 8 clocks after restart", v, 1);
    endtask

    task automatic t_oneshot;
        logic [15:0] v;
        logic [7:0] d;
        do_reset();
        wr16(A_RLD_HI, 16'h0003);
        wr(A_MODE, 8'h00);
        wr(A_CTRL, 8'hC0);
        check("R11 output set to polarity on start", tmr_out, 1);
        cyc(3);
        cyc(1);
        rd16(A_CNT_HI, v); check("R6 count 0001h at expiry", v, 1);
        check("R6 output toggled at expiry", tmr_out, 0);
        check("R6 irq at expiry", irq, 1);
        rd(A_CTRL, d); check("R6 enable cleared", d[7], 0);
        cyc(5);
        rd16(A_CNT_HI, v); check("R6 count holds after expiry", v, 1);
        wr(A_CTRL, 8'h00);
        check("R11 disable write sets polarity level", tmr_out, 0);
    endtask

    task automatic t_byte_write;
        logic [15:0] v;
        do_reset();
        wr16(A_RLD_HI, 16'hFFFF);
        wr(A_MODE, 8'h01);
        wr(A_CTRL, 8'h80);
        wr(A_CNT_LO, 8'h80);
        rd16(A_CNT_HI, v); check("R7 low byte loaded while running", v, 16'h0080);
        cyc(1);
        rd16(A_CNT_HI, v); check("R7 counting from new value", v, 16'h0081);
        wr(A_CNT_HI, 8'h12);
        rd16(A_CNT_HI, v); check("R7 high byte loaded, low kept", v, 16'h1281);
        cyc(2);
        rd16(A_CNT_HI, v); check("R7 counting continues", v, 16'h1283);
    endtask

    task automatic t_edge_count;
        logic [15:0] v;
        do_reset();
        wr16(A_RLD_HI, 16'h0003);
        wr(A_MODE, 8'h02);
        wr(A_CTRL, 8'h80);
        @(negedge clk); tmr_in = 1'b1;
        repeat (2) @(posedge clk); #1;
        rd16(A_CNT_HI, v); check("R8 no count before third edge", v, 0);
        @(posedge clk); #1;
        rd16(A_CNT_HI, v); check("R8 count on third edge", v, 1);
        @(negedge clk); tmr_in = 1'b0;
        cyc(5);
        rd16(A_CNT_HI, v); check("R8 falling edge ignored", v, 1);
        pulse_in();
        pulse_in();
        rd16(A_CNT_HI, v); check("R8 three rising edges", v, 3);
        pulse_in();
        rd16(A_CNT_HI, v); check("R5 edge count restart", v, 1);
        check("R5 edge count output toggled", tmr_out, 1);
    endtask

    task automatic t_pwm;
        do_reset();
        wr16(A_RLD_HI, 16'h0009);
        wr16(A_CMP_HI, 16'h0003);
        wr(A_MODE, 8'h03);
        wr(A_CTRL, 8'h80);
        cyc(3);
        check("R9 idle level before match", tmr_out, 0);
        cyc(1);
        check("R9 active after match", tmr_out, 1);
        cyc(5);
        check("R9 active until restart", tmr_out, 1);
        cyc(1);
        check("R9 back to polarity at restart", tmr_out, 0);
        cyc(3);
        check("R9 active again next period", tmr_out, 1);
    endtask

    task automatic t_capture;
        logic [15:0] v;
        logic [7:0] d;
        do_reset();
        wr16(A_CNT_HI, 16'h1234);
        wr16(A_RLD_HI, 16'hFFFF);
        wr(A_MODE, 8'h04);
        wr(A_CTRL, 8'hB8);
        @(negedge clk); tmr_in = 1'b1;
        repeat (3) @(posedge clk); #1;
        check("R10 irq on capture", irq, 1);
        rd16(A_CMP_HI, v); check("R10 captured count", v, 16'h1234);
        cyc(1);
        check("R10 irq single cycle", irq, 0);
        rd(A_CTRL, d); check("R10 still running", d[7], 1);
        cyc(123);
        rd16(A_CNT_HI, v); check("R10 count before step", v, 16'h1234);
        cyc(1);
        rd16(A_CNT_HI, v); check("R10 counter keeps running", v, 16'h1235);
    endtask

    task automatic t_bad_mode;
        logic [15:0] v;
        do_reset();
        wr(A_MODE, 8'h07);
        wr(A_CTRL, 8'h80);
        cyc(10);
        rd16(A_CNT_HI, v); check("R12 count held in undefined mode", v, 0);
        check("R12 output held in undefined mode", tmr_out, 0);
    endtask

    initial begin
        t_reset_map();
        t_continuous();
        t_prescale();
        t_divider_clear();
        t_oneshot();
        t_byte_write();
        t_edge_count();
        t_pwm();
        t_capture();
        t_bad_mode();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule